// File: doc/BRIEF.md
# Serial Debug Probe Shifter

This block lets a wide internal status word be watched on an oscilloscope using only two spare pins. It holds a copy of a 30-bit word and sends it out one bit per bit period on a data pin. A second pin goes high for the first slot of every frame, which gives the scope a clean trigger. A frame always has 32 slots. Slots 0 to 29 carry word bits 0 to 29 in ascending order. Slots 30 and 31 are quiet gap slots.

The bit period is set by a one-cycle enable tick in the system clock domain, typically around 1 MHz. There are two run modes. In free-run mode, frames follow one another with no gap. In triggered mode, the logic that updates the monitored word pulses a start request, and exactly one frame is sent per request. A request that arrives during a frame is held and served immediately after that frame.

The word input is sampled, not streamed. It is copied at the tick that opens a frame and needs no handshake, so there is no back-pressure at the block's edge. All pins are plain level or pulse signals.

Top module: `dbgp_probe_ser`

## Requirements
- R1: A synchronous active-high reset drives both pins low, empties the holding register, drops any remembered request and leaves the block idle. Ticks seen after reset produce no frame until a frame is started.
- R2: The two pins are registers that change only at a clock edge where the bit tick is high. On all other cycles they hold their values.
- R3: Within a frame, slot k carries bit k of the captured word on the data pin, for k from 0 to 29. Bit 0 goes first.
- R4: Slots 30 and 31 of every frame drive the data pin low.
- R5: The marker pin is high exactly during slot 0 of each frame and low in every other slot and while idle.
- R6: The word is copied at the tick that opens a frame. Changes to the word input during the frame do not affect that frame.
- R7: With free-run high, a frame starts at the first tick while idle, and each new frame begins at the tick after slot 31 with no gap. The word is recaptured at each frame start. If free-run is lowered during a frame, that frame completes and the block then goes idle.
- R8: In triggered mode (free-run low) with no request, the pins stay low. Each request produces exactly one frame.
- R9: A request made during a frame is remembered. The next frame opens at the tick that follows slot 31, with no idle slot in between.
- R10: A request pulsed on a cycle without a tick while idle is held, and the frame opens at the next tick.
- R11: Several requests during one frame produce only one further frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_tick | input | 1 | One-cycle enable marking each bit period |
| free_run | input | 1 | 1 = continuous frames, 0 = one frame per request |
| start_req | input | 1 | One-cycle request for a frame in triggered mode |
| word_in | input | WORD_W (30) | Monitored status word |
| ser_data | output | 1 | Serial data pin |
| ser_mark | output | 1 | Frame marker pin, high in slot 0 |

## Verification
Every pin result belongs to the clock edge at which the tick is sampled high, so the bench raises the tick for one cycle, samples the pins at the next falling edge, and then confirms they are unchanged after one further tick-free cycle. The capture of a new word also lands at the opening tick, so word changes and requests are applied between ticks and judged only at the slot they should first affect. Expected slot contents come from a bench model of the frame layout, and back-to-back behaviour is checked by requiring slot 0 at the very next tick after slot 31.

// File: rtl/dbgp_pkg.sv
package dbgp_pkg;

  typedef enum logic {
    RUN_TRIG = 1'b0,
    RUN_FREE = 1'b1
  } run_mode_e;

  function automatic int slot_bits(input int n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/dbgp_frame_ctrl.sv
module dbgp_frame_ctrl
  import dbgp_pkg::*;
#(
  parameter int FRAME_SLOTS = 32,
  parameter int SLOT_W      = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_tick,
  input  run_mode_e         mode,
  input  logic              start_req,
  output logic              load,
  output logic              run_nxt,
  output logic [SLOT_W-1:0] slot_nxt,
  output logic              active_q,
  output logic [SLOT_W-1:0] slot_q
);

  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(FRAME_SLOTS - 1);

  logic pend_q;
  logic want_frame;
  logic at_end;

  assign want_frame = (mode == RUN_FREE) | pend_q | start_req;
  assign at_end     = active_q && (slot_q == LAST_SLOT);

  always_comb begin
    load     = 1'b0;
    run_nxt  = active_q;
    slot_nxt = slot_q;
    if (bit_tick) begin
      if (!active_q || at_end) begin
        run_nxt  = want_frame;
        slot_nxt = '0;
        load     = want_frame;
      end else begin
        slot_nxt = slot_q + SLOT_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      slot_q   <= '0;
      pend_q   <= 1'b0;
    end else begin
      active_q <= run_nxt;
      slot_q   <= slot_nxt;
      pend_q   <= load ? 1'b0 : (pend_q | start_req);
    end
  end

endmodule

// File: rtl/dbgp_word_hold.sv
module dbgp_word_hold #(
  parameter int WORD_W = 30
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [WORD_W-1:0] word_in,
  output logic [WORD_W-1:0] hold_q,
  output logic [WORD_W-1:0] word_sel
);

  always_ff @(posedge clk) begin
    if (rst) hold_q <= '0;
    else if (load) hold_q <= word_in;
  end

  // the opening slot must show the word being captured right now
  assign word_sel = load ? word_in : hold_q;

endmodule

// File: rtl/dbgp_bit_pick.sv
module dbgp_bit_pick #(
  parameter int WORD_W      = 30,
  parameter int FRAME_SLOTS = 32,
  parameter int SLOT_W      = 5
) (
  input  logic [WORD_W-1:0] word,
  input  logic [SLOT_W-1:0] slot,
  output logic              bit_o
);

  logic [FRAME_SLOTS-1:0] padded;

  for (genvar i = 0; i < FRAME_SLOTS; i++) begin : g_slot
    if (i < WORD_W) begin : g_data
      assign padded[i] = word[i];
    end else begin : g_gap
      assign padded[i] = 1'b0;
    end
  end

  assign bit_o = padded[slot];

endmodule

// File: rtl/dbgp_pin_reg.sv
module dbgp_pin_reg (
  input  logic clk,
  input  logic rst,
  input  logic bit_tick,
  input  logic data_d,
  input  logic mark_d,
  output logic ser_data,
  output logic ser_mark
);

  always_ff @(posedge clk) begin
    if (rst) begin
      ser_data <= 1'b0;
      ser_mark <= 1'b0;
    end else if (bit_tick) begin
      ser_data <= data_d;
      ser_mark <= mark_d;
    end
  end

endmodule

// File: rtl/dbgp_probe_ser.sv
module dbgp_probe_ser
  import dbgp_pkg::*;
#(
  parameter int WORD_W      = 30,
  parameter int FRAME_SLOTS = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_tick,
  input  logic              free_run,
  input  logic              start_req,
  input  logic [WORD_W-1:0] word_in,
  output logic              ser_data,
  output logic              ser_mark
);

  localparam int SLOT_W = slot_bits(FRAME_SLOTS);

  run_mode_e         mode;
  logic              load;
  logic              run_nxt;
  logic [SLOT_W-1:0] slot_nxt;
  logic              active_q;
  logic [SLOT_W-1:0] slot_q;
  logic [WORD_W-1:0] hold_q;
  logic [WORD_W-1:0] word_sel;
  logic              pick_bit;
  logic              data_d;
  logic              mark_d;

  assign mode = free_run ? RUN_FREE : RUN_TRIG;

  dbgp_frame_ctrl #(
    .FRAME_SLOTS(FRAME_SLOTS),
    .SLOT_W     (SLOT_W)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .bit_tick (bit_tick),
    .mode     (mode),
    .start_req(start_req),
    .load     (load),
    .run_nxt  (run_nxt),
    .slot_nxt (slot_nxt),
    .active_q (active_q),
    .slot_q   (slot_q)
  );

  dbgp_word_hold #(
    .WORD_W(WORD_W)
  ) u_hold (
    .clk     (clk),
    .rst     (rst),
    .load    (load),
    .word_in (word_in),
    .hold_q  (hold_q),
    .word_sel(word_sel)
  );

  dbgp_bit_pick #(
    .WORD_W     (WORD_W),
    .FRAME_SLOTS(FRAME_SLOTS),
    .SLOT_W     (SLOT_W)
  ) u_pick (
    .word (word_sel),
    .slot (slot_nxt),
    .bit_o(pick_bit)
  );

  assign data_d = run_nxt & pick_bit;
  assign mark_d = run_nxt & (slot_nxt == '0);

  dbgp_pin_reg u_pins (
    .clk     (clk),
    .rst     (rst),
    .bit_tick(bit_tick),
    .data_d  (data_d),
    .mark_d  (mark_d),
    .ser_data(ser_data),
    .ser_mark(ser_mark)
  );

endmodule

// File: rtl/dbgp_probe_chk.sv
module dbgp_probe_chk #(
  parameter int WORD_W      = 30,
  parameter int FRAME_SLOTS = 32,
  parameter int SLOT_W      = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              bit_tick,
  input logic              free_run,
  input logic              ser_data,
  input logic              ser_mark,
  input logic              active_q,
  input logic [SLOT_W-1:0] slot_q,
  input logic [WORD_W-1:0] hold_q
);

  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(FRAME_SLOTS - 1);
  localparam logic [SLOT_W-1:0] DATA_END  = SLOT_W'(WORD_W);

  logic armed;
  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else armed <= 1'b1;
  end

  // R1
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!ser_data && !ser_mark && !active_q));

  // R2
  a_r2_pins_hold: assert property (@(posedge clk) disable iff (rst || !armed)
    !$past(bit_tick) |-> ($stable(ser_data) && $stable(ser_mark)));

  // R3
  a_r3_bit_matches: assert property (@(posedge clk) disable iff (rst)
    (active_q && slot_q < DATA_END) |-> (ser_data == hold_q[slot_q]));

  // R4
  a_r4_gap_low: assert property (@(posedge clk) disable iff (rst)
    (active_q && slot_q >= DATA_END) |-> !ser_data);

  // R5
  a_r5_mark_first: assert property (@(posedge clk) disable iff (rst)
    ser_mark |-> (active_q && slot_q == '0));

  // R6
  a_r6_hold_frozen: assert property (@(posedge clk) disable iff (rst)
    (active_q && !(bit_tick && slot_q == LAST_SLOT)) |=> $stable(hold_q));

  // R7
  a_r7_back_to_back: assert property (@(posedge clk) disable iff (rst)
    (free_run && active_q && slot_q == LAST_SLOT && bit_tick)
      |=> (active_q && slot_q == '0 && ser_mark));

endmodule

bind dbgp_probe_ser dbgp_probe_chk #(
  .WORD_W     (WORD_W),
  .FRAME_SLOTS(FRAME_SLOTS),
  .SLOT_W     (SLOT_W)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .bit_tick(bit_tick),
  .free_run(free_run),
  .ser_data(ser_data),
  .ser_mark(ser_mark),
  .active_q(active_q),
  .slot_q  (slot_q),
  .hold_q  (hold_q)
);

// File: tb/dbgp_probe_ser_bench.sv
module dbgp_probe_ser_bench;

  localparam int CLK_P  = 10;
  localparam int WORD_W = 30;
  localparam int SLOTS  = 32;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              bit_tick = 1'b0;
  logic              free_run = 1'b0;
  logic              start_req = 1'b0;
  logic [WORD_W-1:0] word_in = '0;
  logic              ser_data;
  logic              ser_mark;

  int n_run  = 0;
  int n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  dbgp_probe_ser #(
    .WORD_W     (WORD_W),
    .FRAME_SLOTS(SLOTS)
  ) u_dbgp_probe_ser (
    .clk      (clk),
    .rst      (rst),
    .bit_tick (bit_tick),
    .free_run (free_run),
    .start_req(start_req),
    .word_in  (word_in),
    .ser_data (ser_data),
    .ser_mark (ser_mark)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // one tick, sample after its edge, then confirm one quiet cycle changes nothing
  task automatic tick_sample(output logic d, output logic m);
    @(negedge clk); bit_tick = 1'b1;
    @(negedge clk); bit_tick = 1'b0;
    d = ser_data;
    m = ser_mark;
    @(negedge clk);
    chk("R2 data held between ticks", ser_data, d);
    chk("R2 mark held between ticks", ser_mark, m);
  endtask

  task automatic pulse_start();
    @(negedge clk); start_req = 1'b1;
    @(negedge clk); start_req = 1'b0;
  endtask

  task automatic idle_ticks(input int n, input string tag);
    logic d, m;
    for (int i = 0; i < n; i++) begin
      tick_sample(d, m);
      chk({tag, " data idle"}, d, 1'b0);
      chk({tag, " mark idle"}, m, 1'b0);
    end
  endtask

  task automatic check_frame(input string tag, input logic [WORD_W-1:0] w,
                             input int chg_at, input logic [WORD_W-1:0] chg_w,
                             input int req_at, input int free_off_at);
    logic d, m;
    for (int k = 0; k < SLOTS; k++) begin
      tick_sample(d, m);
      if (k < WORD_W) chk($sformatf("R3 %s slot %0d", tag, k), d, w[k]);
      else            chk($sformatf("R4 %s slot %0d", tag, k), d, 1'b0);
      chk($sformatf("R5 %s mark slot %0d", tag, k), m, (k == 0));
      if (k == chg_at) word_in = chg_w;
      if (k == req_at) begin
        pulse_start();
        pulse_start();
      end
      if (k == free_off_at) free_run = 1'b0;
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 data after reset", ser_data, 1'b0);
    chk("R1 mark after reset", ser_mark, 1'b0);
    rst = 1'b0;
    idle_ticks(3, "R1 R8 no request");
  endtask

  task automatic t_single();
    word_in = 30'h2A5C_3E91;
    pulse_start();  // R10: request on a cycle without tick
    check_frame("R10 single", 30'h2A5C_3E91, -1, '0, -1, -1);
    idle_ticks(3, "R8 one frame per request");
  endtask

  task automatic t_capture();
    word_in = 30'h1234_5678;
    pulse_start();
    check_frame("R6 frozen word", 30'h1234_5678, 5, ~30'h1234_5678, -1, -1);
    idle_ticks(2, "R8 after capture frame");
  endtask

  task automatic t_queued();
    word_in = 30'h0F0F_0F0F;
    pulse_start();
    check_frame("R9 first", 30'h0F0F_0F0F, 10, 30'h3333_CCCC, 10, -1);
    check_frame("R9 queued next", 30'h3333_CCCC, -1, '0, -1, -1);
    idle_ticks(3, "R11 single extra frame");
  endtask

  task automatic t_free();
    word_in  = 30'h3FFF_0001;
    free_run = 1'b1;
    check_frame("R7 free first", 30'h3FFF_0001, 31, 30'h2000_8421, -1, -1);
    check_frame("R7 free second", 30'h2000_8421, -1, '0, -1, 20);
    idle_ticks(3, "R7 stop after free-run off");
  endtask

  task automatic t_reset_mid();
    logic d, m;
    word_in = '1;
    pulse_start();
    for (int k = 0; k < 6; k++) tick_sample(d, m);
    pulse_start();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R1 data after mid-frame reset", ser_data, 1'b0);
    chk("R1 mark after mid-frame reset", ser_mark, 1'b0);
    idle_ticks(3, "R1 request dropped by reset");
  endtask

  initial begin
    t_reset();
    t_single();
    t_capture();
    t_queued();
    t_free();
    t_reset_mid();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule